// File: doc/BRIEF.md
# Two-Row Matrix ECC Codec

This block protects a 32-bit word with a two-row matrix code and shows that the protection works end to end. The word is cut into eight 4-bit symbols. The low four symbols form the upper row and the high four symbols form the lower row, so each column holds two symbols. Each upper-row symbol gets three Hamming check bits, for 12 horizontal bits in total. Each column also gets four vertical bits, which are the XOR of its two symbols, for 16 vertical bits in total. The data travels uncoded, and 28 redundant bits travel beside it.

On the decode side the received data goes back through an identical copy of the encoder. For each column, the received and regenerated check bits, each placed in front of the symbol bits, are subtracted as 7-bit integers. A nonzero difference blames the upper-row symbol of that column. A zero difference together with a nonzero vertical syndrome blames the lower-row symbol. The four vertical syndrome bits of the column are then XORed into the symbol that was blamed.

The block accepts one word per handshake on a valid/ready input. It encodes the word and can invert chosen data bits on the way to the decoder when injection is enabled. One clock later it presents the corrected word, a per-column error flag and the check bits of the original word on a valid/ready output. The input is ready whenever the output register is empty or is being drained in that cycle. A result that is not taken stays unchanged until it is taken.

Top module: `matrix_ecc_codec`

## Requirements
- R1: Symbol k (k = 0..7) occupies data bits [4k+3:4k]. Symbols 0..3 form the upper row and symbols 4..7 the lower row. Column c holds symbols c and c+4, and out_col_err bit c reports column c.
- R2: For upper-row symbol c with bits s3..s0, out_hchk bit 3c equals s3^s1^s0, bit 3c+1 equals s3^s2^s0, and bit 3c+2 equals s3^s2^s1. These bits are computed on the word before injection.
- R3: out_vchk bit i equals in_data bit i XOR in_data bit i+16, for i = 0..15, computed on the word before injection.
- R4: With no injected error, out_data equals the accepted in_data and out_col_err is all zeros.
- R5: While inj_en is high, every data bit whose inj_mask bit is 1 is inverted before decoding, and the check bits are never inverted. While inj_en is low, inj_mask has no effect on any output.
- R6: An injected error of one or two bits inside one upper-row symbol is fully corrected, and the flag of its column is set.
- R7: Any nonzero injected error inside one lower-row symbol is fully corrected, and the flag of its column is set.
- R8: Errors in several columns, with at most one faulty symbol per column, are corrected independently, and each affected column raises its own flag.
- R9: The upper-row pattern 0111 (symbol bits 0, 1 and 2) leaves the horizontal syndrome at zero. For that pattern the column flag is set, the upper symbol stays inverted, and the lower symbol of the same column is also inverted by 0111.
- R10: in_ready equals !out_valid || out_ready. An accepted word produces out_valid high after the next clock edge. While out_valid is high and out_ready is low, all outputs stay stable.
- R11: During and after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input word is offered |
| in_ready | output | 1 | The block can take a word this cycle |
| in_data | input | 32 | Word to encode |
| inj_en | input | 1 | Enables test error injection |
| inj_mask | input | 32 | Data bits to invert before decoding |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_data | output | 32 | Corrected word |
| out_col_err | output | 4 | Error detected, one bit per column |
| out_hchk | output | 12 | Horizontal check bits of the original word |
| out_vchk | output | 16 | Vertical check bits of the original word |

## Verification
The hardest case to reach is the blind spot in the horizontal code. An upper-row error shaped exactly 0111 changes none of the Hamming bits, so the decoder blames the lower row of that column. Random masks would seldom hit this. The stimulus therefore injects that exact mask and expects the spread error described in R9. The stimulus also throttles out_ready with a fixed pattern so that words arrive while results are held. This shows that stalled results stay stable and are delivered in order.

// File: rtl/mecc_pkg.sv
package mecc_pkg;
  localparam int SYM_W    = 4;
  localparam int HAM_BITS = 3;

  // Hamming check bits of one 4-bit symbol: bit0 = s3^s1^s0, bit1 = s3^s2^s0, bit2 = s3^s2^s1
  function automatic logic [HAM_BITS-1:0] sym_hamming(input logic [SYM_W-1:0] s);
    return {s[3] ^ s[2] ^ s[1], s[3] ^ s[2] ^ s[0], s[3] ^ s[1] ^ s[0]};
  endfunction
endpackage

// File: rtl/mecc_encoder.sv
module mecc_encoder #(
  parameter int COLS = 4,
  localparam int SW  = mecc_pkg::SYM_W,
  localparam int HB  = mecc_pkg::HAM_BITS,
  localparam int RW  = COLS * SW,
  localparam int DW  = 2 * RW,
  localparam int HW  = HB * COLS
) (
  input  logic [DW-1:0] data,
  output logic [HW-1:0] hchk,
  output logic [RW-1:0] vchk
);
  // horizontal bits cover the upper row only
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign hchk[HB*c +: HB] = mecc_pkg::sym_hamming(data[SW*c +: SW]);
  end

  // vertical bits fold the lower row onto the upper row
  assign vchk = data[RW-1:0] ^ data[DW-1:RW];
endmodule

// File: rtl/mecc_decoder.sv
module mecc_decoder #(
  parameter int COLS = 4,
  localparam int SW  = mecc_pkg::SYM_W,
  localparam int HB  = mecc_pkg::HAM_BITS,
  localparam int RW  = COLS * SW,
  localparam int DW  = 2 * RW,
  localparam int HW  = HB * COLS,
  localparam int FW  = HB + SW
) (
  input  logic [DW-1:0]   rx_data,
  input  logic [HW-1:0]   rx_hchk,
  input  logic [RW-1:0]   rx_vchk,
  output logic [DW-1:0]   fixed,
  output logic [COLS-1:0] col_err
);
  logic [HW-1:0] re_hchk;
  logic [RW-1:0] re_vchk;
  logic [RW-1:0] vsyn;

  // the same encoder, run again on the received data
  mecc_encoder #(.COLS(COLS)) u_regen (
    .data (rx_data),
    .hchk (re_hchk),
    .vchk (re_vchk)
  );

  assign vsyn = re_vchk ^ rx_vchk;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [SW-1:0] up_sym, lo_sym, grp;
    logic [FW-1:0] rx_field, re_field, hdiff;
    logic          up_hit, lo_hit;

    assign up_sym = rx_data[SW*c +: SW];
    assign lo_sym = rx_data[RW + SW*c +: SW];
    assign grp    = vsyn[SW*c +: SW];

    // check bits placed above the symbol bits, first check bit most significant
    assign rx_field = {rx_hchk[HB*c], rx_hchk[HB*c+1], rx_hchk[HB*c+2], up_sym};
    assign re_field = {re_hchk[HB*c], re_hchk[HB*c+1], re_hchk[HB*c+2], up_sym};
    assign hdiff    = rx_field - re_field;

    assign up_hit = |hdiff;
    assign lo_hit = !up_hit && (|grp);

    assign fixed[SW*c +: SW]      = up_sym ^ (up_hit ? grp : '0);
    assign fixed[RW + SW*c +: SW] = lo_sym ^ (lo_hit ? grp : '0);
    assign col_err[c]             = up_hit | lo_hit;
  end
endmodule

// File: rtl/mecc_out_stage.sv
module mecc_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_payload,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_payload
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid   <= 1'b0;
      dn_payload <= '0;
    end else begin
      if (take) begin
        dn_valid   <= 1'b1;
        dn_payload <= up_payload;
      end else if (dn_ready) begin
        dn_valid   <= 1'b0;
      end
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_payload));

  assert_accept_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready |=> dn_valid);
endmodule

// File: rtl/matrix_ecc_codec.sv
module matrix_ecc_codec #(
  parameter int COLS = 4,
  localparam int SW  = mecc_pkg::SYM_W,
  localparam int HB  = mecc_pkg::HAM_BITS,
  localparam int RW  = COLS * SW,
  localparam int DW  = 2 * RW,
  localparam int HW  = HB * COLS,
  localparam int PW  = DW + COLS + HW + RW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  input  logic            inj_en,
  input  logic [DW-1:0]   inj_mask,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_data,
  output logic [COLS-1:0] out_col_err,
  output logic [HW-1:0]   out_hchk,
  output logic [RW-1:0]   out_vchk
);
  logic [HW-1:0]   tx_hchk;
  logic [RW-1:0]   tx_vchk;
  logic [DW-1:0]   rx_data;
  logic [DW-1:0]   fixed;
  logic [COLS-1:0] col_err;
  logic [PW-1:0]   result;
  logic [PW-1:0]   held;

  mecc_encoder #(.COLS(COLS)) u_enc (
    .data (in_data),
    .hchk (tx_hchk),
    .vchk (tx_vchk)
  );

  // test injection corrupts data bits only
  assign rx_data = in_data ^ (inj_en ? inj_mask : '0);

  mecc_decoder #(.COLS(COLS)) u_dec (
    .rx_data (rx_data),
    .rx_hchk (tx_hchk),
    .rx_vchk (tx_vchk),
    .fixed   (fixed),
    .col_err (col_err)
  );

  assign result = {fixed, col_err, tx_hchk, tx_vchk};

  mecc_out_stage #(.W(PW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (in_valid),
    .up_ready   (in_ready),
    .up_payload (result),
    .dn_valid   (out_valid),
    .dn_ready   (out_ready),
    .dn_payload (held)
  );

  assign {out_data, out_col_err, out_hchk, out_vchk} = held;

  assert_clean_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !inj_en |=> out_data == $past(in_data) && out_col_err == '0);

  assert_upper_fix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && inj_en && (inj_mask[DW-1:SW] == '0) && (inj_mask[SW-1:0] != '0)
      && ($countones(inj_mask) <= 2)
    |=> out_data == $past(in_data) && out_col_err == COLS'(1));

  assert_lower_fix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && inj_en && (inj_mask[DW-1:RW+SW] == '0) && (inj_mask[RW-1:0] == '0)
      && (inj_mask[RW +: SW] != '0)
    |=> out_data == $past(in_data) && out_col_err == COLS'(1));

  assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/test_matrix_ecc_codec.sv
`timescale 1ns/1ps
module test_matrix_ecc_codec;
  typedef struct packed {
    logic [31:0] w;
    logic [3:0]  f;
    logic [11:0] h;
    logic [15:0] v;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        inj_en = 1'b0;
  logic [31:0] inj_mask = '0;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic [3:0]  out_col_err;
  logic [11:0] out_hchk;
  logic [15:0] out_vchk;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;
  int cyc      = 0;
  exp_t  sb[$];
  string tags[$];

  always #2.5 clk = ~clk;

  matrix_ecc_codec i_matrix_ecc_codec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .inj_en(inj_en), .inj_mask(inj_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_col_err(out_col_err), .out_hchk(out_hchk), .out_vchk(out_vchk)
  );

  // consumer throttle: drops ready one cycle in five
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) out_ready <= 1'b1;
    else        out_ready <= (cyc % 5) != 3;
  end

  function automatic logic [11:0] ref_h(input logic [31:0] d);
    logic [11:0] h;
    for (int c = 0; c < 4; c++) begin
      logic [3:0] s;
      s = d[4*c +: 4];
      h[3*c]   = s[3] ^ s[1] ^ s[0];
      h[3*c+1] = s[3] ^ s[2] ^ s[0];
      h[3*c+2] = s[3] ^ s[2] ^ s[1];
    end
    return h;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic en, input logic [31:0] m,
                      input logic [31:0] ew, input logic [3:0] ef, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; inj_en = en; inj_mask = m;
    while (!in_ready) @(negedge clk);
    sb.push_back('{w: ew, f: ef, h: ref_h(d), v: d[15:0] ^ d[31:16]});
    tags.push_back(tag);
    @(posedge clk);
    #1;
    in_valid = 1'b0; inj_en = 1'b0; inj_mask = '0;
    check(out_valid == 1'b1, "R10 valid after accept", 32'(out_valid), 32'd1);
  endtask

  // scoreboard monitor
  logic        hold_seen = 1'b0;
  logic [31:0] hold_w;
  logic [3:0]  hold_f;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_seen && out_valid)
        check(out_data == hold_w && out_col_err == hold_f, "R10 stall hold", out_data, hold_w);
      hold_seen = out_valid && !out_ready;
      hold_w = out_data;
      hold_f = out_col_err;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10 unexpected output", out_data, 32'd0);
        end else begin
          exp_t  e;
          string t;
          e = sb.pop_front();
          t = tags.pop_front();
          check(out_data == e.w, {t, " word"}, out_data, e.w);
          check(out_col_err == e.f, {t, " flags"}, 32'(out_col_err), 32'(e.f));
          check(out_hchk == e.h, "R2 hchk", 32'(out_hchk), 32'(e.h));
          check(out_vchk == e.v, "R3 vchk", 32'(out_vchk), 32'(e.v));
        end
      end
    end
  end

  initial begin
    #(40000 * 5);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R11 valid in reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R11 ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 valid after reset", 32'(out_valid), 32'd0);

    // R4 / R1: clean words
    send(32'h0000_0000, 0, '0, 32'h0000_0000, 4'b0000, "R4 zero");
    send(32'hFFFF_FFFF, 0, '0, 32'hFFFF_FFFF, 4'b0000, "R4 ones");
    send(32'h1234_5678, 0, '0, 32'h1234_5678, 4'b0000, "R4 mixed");
    send(32'hA5A5_3C3C, 0, '0, 32'hA5A5_3C3C, 4'b0000, "R4 pattern");
    // R5: mask without enable has no effect
    send(32'hDEAD_BEEF, 0, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 4'b0000, "R5 mask ignored");
    // R6: upper row, bits 0 and 2; single bit in symbol 2
    send(32'h1234_5678, 1, 32'h0000_0005, 32'h1234_5678, 4'b0001, "R6 bits0_2");
    send(32'hCAFE_F00D, 1, 32'h0000_0800, 32'hCAFE_F00D, 4'b0100, "R6 single");
    // R7: lower row, whole symbol 4; symbol 7 three bits
    send(32'h8765_4321, 1, 32'h000F_0000, 32'h8765_4321, 4'b0001, "R7 sym4");
    send(32'h0F0F_0F0F, 1, 32'hB000_0000, 32'h0F0F_0F0F, 4'b1000, "R7 sym7");
    // R8: column 1 upper and column 2 lower at once
    send(32'h5555_AAAA, 1, 32'h0500_0030, 32'h5555_AAAA, 4'b0110, "R8 two cols");
    send(32'h0246_8ACE, 1, 32'h0000_3300, 32'h0246_8ACE, 4'b1100, "R8 upper pair");
    // R9: horizontal blind pattern spreads to the lower symbol
    send(32'h1357_9BDF, 1, 32'h0000_0007, 32'h1357_9BDF ^ 32'h0007_0007, 4'b0001, "R9 blind");
    // R10: back-to-back words under throttling
    for (int k = 0; k < 12; k++)
      send(32'h9E37_79B9 * (k + 1), 0, '0, 32'h9E37_79B9 * (k + 1), 4'b0000, "R10 burst");

    for (int k = 0; k < 200 && sb.size() != 0; k++) @(negedge clk);
    check(sb.size() == 0, "R10 drain", 32'(sb.size()), 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule